// File: doc/BRIEF.md
# Host-Port Byte FIFO with Command-Buffer Steering

This block sits behind one host register address of a storage-bus controller. Host writes to that address are steered to one of two stores. In data mode they go into a small byte FIFO, which the host drains through the same address. In command mode they go into a separate command buffer that the controller reads back by index when it dispatches the command.

The data FIFO keeps a write pointer, a read pointer and a signed byte count. It reports how many bytes are loaded. When reads catch up with writes, both pointers fall back to zero. A write is refused one entry before the array is physically full, so at most DATA_DEPTH-1 bytes are held between drains. A refused write in either mode raises a one-cycle overrun pulse.

A small state machine selects the mode. It has two states:
- ST_DATA is the reset state.
- ST_CMD is the command-mode state.

It has two transitions:
- T_ENTER_CMD moves from ST_DATA to ST_CMD when `sel_stop` pulses. The controller raises this pulse after a select-and-stop command.
- T_DISPATCH moves from ST_CMD back to ST_DATA when `cmd_done` pulses, once the command has been handed on.

Both pulses restart the command-buffer length at zero.

Top module: `hostfifo_redirect`

## Requirements
- R1: After reset the block is in ST_DATA. `cmd_mode` is 0, `fifo_flags`, `byte_count`, `cmd_len` and `overrun` are 0, and `host_rdata` is 0.
- R2: In ST_DATA, a host write with no flush stores the byte. One clock later `fifo_flags` and `byte_count` are each one higher.
- R3: In ST_DATA, a write is dropped when the write pointer equals DATA_DEPTH-1, even if some bytes have already been read out. On the clock after the dropped write, `overrun` is 1 for exactly one cycle and `fifo_flags` is unchanged. With the default depth this means 15 bytes are held.
- R4: A host read with `phase_bits` not equal to 2'b00 on a non-empty FIFO returns the oldest byte on `host_rdata` one clock later, in write order. The same read lowers `fifo_flags` and `byte_count` by one.
- R5: A host read with `phase_bits` = 2'b00 returns 0 on `host_rdata` and leaves `fifo_flags` and `byte_count` unchanged.
- R6: When a read empties the FIFO, both pointers return to 0, so a full DATA_DEPTH-1 bytes can be written again. A read of an empty FIFO leaves `host_rdata` and `byte_count` unchanged.
- R7: In ST_CMD, host writes append to the command buffer. `cmd_len` rises by one, the data FIFO is untouched, and `cmd_byte` shows the byte stored at index `cmd_idx`.
- R8: In ST_CMD, a write with `cmd_len` = CMD_DEPTH is dropped. `overrun` pulses for one cycle and `cmd_len` stays at CMD_DEPTH.
- R9: `sel_stop` enters ST_CMD (transition T_ENTER_CMD) and `cmd_done` returns to ST_DATA (transition T_DISPATCH). Either pulse resets `cmd_len` to 0. If both are high together, `cmd_done` wins and the block ends in ST_DATA.
- R10: `flush` clears both pointers, `byte_count` and `fifo_flags` in one clock. A write or read in the same cycle is dropped, and the command buffer is not affected.
- R11: When `host_wr` and `host_rd` are both high, only the write is serviced: `host_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe to the FIFO address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the FIFO address |
| host_rdata | output | 8 | Registered read byte |
| phase_bits | input | 2 | Bus phase bits from the status register; 2'b00 means data-out |
| flush | input | 1 | Flush command pulse |
| sel_stop | input | 1 | Enter command mode (after select-and-stop) |
| cmd_done | input | 1 | Command dispatched; return to data mode |
| cmd_mode | output | 1 | 1 while in ST_CMD |
| cmd_len | output | 6 | Bytes held in the command buffer |
| cmd_idx | input | 5 | Command buffer read index |
| cmd_byte | output | 8 | Command buffer byte at `cmd_idx` |
| fifo_flags | output | 5 | Bytes loaded in the data FIFO |
| byte_count | output | 6 | Signed data byte count |
| overrun | output | 1 | One-cycle pulse for a dropped write |

## Verification
A stale write pointer shows up at the port as an early or late `overrun`. The overrun point is measured in bytes written since the last drain, so a pointer that fails to reset on drain becomes visible within DATA_DEPTH-1 writes.

A wrong mode state sends bytes to the wrong store. This appears on the next clock as `fifo_flags` moving while `cmd_len` stays still, or the other way round.

A read pointer that is off by one returns bytes out of order on the very next read. The scoreboard compares every read against the byte it expects.

// File: rtl/hostfifo_pkg.sv
package hostfifo_pkg;
    typedef enum logic [0:0] {
        ST_DATA = 1'b0,
        ST_CMD  = 1'b1
    } hf_state_t;

    localparam logic [1:0] PHASE_DATA_OUT = 2'b00;
endpackage

// File: rtl/hfifo_data_store.sv
module hfifo_data_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 wr_i,
    input  logic [DW-1:0]        wr_data_i,
    input  logic                 rd_i,
    input  logic                 phase_zero_i,
    output logic [DW-1:0]        rd_data_o,
    output logic                 ovr_o,
    output logic [PW:0]          flags_o,
    output logic signed [CW-1:0] count_o
);
    logic [DW-1:0]        mem [DEPTH];
    logic [PW-1:0]        wptr_q, rptr_q, rptr_inc;
    logic signed [CW-1:0] cnt_q;
    logic [DW-1:0]        rd_q;
    logic                 ovr_q;
    logic                 stop_wr, can_rd, do_store;

    assign stop_wr  = (wptr_q == PW'(DEPTH - 1));
    assign can_rd   = (rptr_q < wptr_q);
    assign rptr_inc = rptr_q + 1'b1;
    assign do_store = !flush_i && wr_i && !stop_wr;

    always_ff @(posedge clk) begin
        if (do_store) mem[wptr_q] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            ovr_q  <= 1'b0;
        end else begin
            ovr_q <= 1'b0;
            if (flush_i) begin
                wptr_q <= '0;
                rptr_q <= '0;
                cnt_q  <= '0;
            end else if (wr_i) begin
                if (stop_wr) begin
                    ovr_q <= 1'b1;
                end else begin
                    wptr_q <= wptr_q + 1'b1;
                    cnt_q  <= cnt_q + CW'(1);
                end
            end else if (rd_i) begin
                if (phase_zero_i) begin
                    rd_q <= '0;
                    if (rptr_q == wptr_q) begin
                        rptr_q <= '0;
                        wptr_q <= '0;
                    end
                end else if (can_rd) begin
                    rd_q  <= mem[rptr_q];
                    cnt_q <= cnt_q - CW'(1);
                    if (rptr_inc == wptr_q) begin
                        rptr_q <= '0;
                        wptr_q <= '0;
                    end else begin
                        rptr_q <= rptr_inc;
                    end
                end else begin
                    rptr_q <= '0;
                    wptr_q <= '0;
                end
            end
        end
    end

    assign rd_data_o = rd_q;
    assign ovr_o     = ovr_q;
    assign flags_o   = {1'b0, wptr_q - rptr_q};
    assign count_o   = cnt_q;
endmodule

// File: rtl/hfifo_cmd_store.sv
module hfifo_cmd_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    output logic [LW-1:0] len_o,
    output logic          ovr_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [LW-1:0] len_q;
    logic          ovr_q;
    logic          has_room;

    assign has_room = (len_q < LW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_i && has_room) mem[len_q[IW-1:0]] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= 1'b0;
            if (clr_i) begin
                len_q <= '0;
            end else if (wr_i) begin
                if (has_room) len_q <= len_q + 1'b1;
                else          ovr_q <= 1'b1;
            end
        end
    end

    assign rd_data_o = mem[rd_idx_i];
    assign len_o     = len_q;
    assign ovr_o     = ovr_q;
endmodule

// File: rtl/hostfifo_redirect.sv
module hostfifo_redirect
    import hostfifo_pkg::*;
#(
    parameter int DATA_DEPTH = 16,
    parameter int CMD_DEPTH  = 32,
    parameter int DW         = 8,
    localparam int PW        = $clog2(DATA_DEPTH),
    localparam int CW        = PW + 2,
    localparam int IW        = $clog2(CMD_DEPTH),
    localparam int LW        = $clog2(CMD_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [DW-1:0]        host_wdata,
    input  logic                 host_rd,
    output logic [DW-1:0]        host_rdata,
    input  logic [1:0]           phase_bits,
    input  logic                 flush,
    input  logic                 sel_stop,
    input  logic                 cmd_done,
    output logic                 cmd_mode,
    output logic [LW-1:0]        cmd_len,
    input  logic [IW-1:0]        cmd_idx,
    output logic [DW-1:0]        cmd_byte,
    output logic [PW:0]          fifo_flags,
    output logic signed [CW-1:0] byte_count,
    output logic                 overrun
);
    hf_state_t st_q, st_d;
    logic      data_wr, data_rd, cmd_wr, cmd_clr;
    logic      data_ovr, cmd_ovr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_DATA;
        else        st_q <= st_d;
    end

    // next state: T_ENTER_CMD and T_DISPATCH, dispatch has priority
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DATA: if (sel_stop && !cmd_done) st_d = ST_CMD;
            ST_CMD:  if (cmd_done)              st_d = ST_DATA;
            default: st_d = ST_DATA;
        endcase
    end

    // outputs: steering of host accesses
    always_comb begin
        data_wr = 1'b0;
        cmd_wr  = 1'b0;
        unique case (st_q)
            ST_DATA: data_wr = host_wr && !flush;
            ST_CMD:  cmd_wr  = host_wr && !flush && !sel_stop && !cmd_done;
            default: ;
        endcase
        data_rd = host_rd && !host_wr && !flush;
        cmd_clr = sel_stop || cmd_done;
    end

    hfifo_data_store #(.DEPTH(DATA_DEPTH), .DW(DW)) u_data (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .wr_i         (data_wr),
        .wr_data_i    (host_wdata),
        .rd_i         (data_rd),
        .phase_zero_i (phase_bits == PHASE_DATA_OUT),
        .rd_data_o    (host_rdata),
        .ovr_o        (data_ovr),
        .flags_o      (fifo_flags),
        .count_o      (byte_count)
    );

    hfifo_cmd_store #(.DEPTH(CMD_DEPTH), .DW(DW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cmd_clr),
        .wr_i      (cmd_wr),
        .wr_data_i (host_wdata),
        .rd_idx_i  (cmd_idx),
        .rd_data_o (cmd_byte),
        .len_o     (cmd_len),
        .ovr_o     (cmd_ovr)
    );

    assign cmd_mode = (st_q == ST_CMD);
    assign overrun  = data_ovr || cmd_ovr;
endmodule

// File: rtl/hostfifo_redirect_chk.sv
module hostfifo_redirect_chk #(
    parameter int DATA_DEPTH = 16,
    parameter int CMD_DEPTH  = 32,
    parameter int DW         = 8,
    localparam int PW        = $clog2(DATA_DEPTH),
    localparam int CW        = PW + 2,
    localparam int LW        = $clog2(CMD_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic [DW-1:0]        host_rdata,
    input logic [1:0]           phase_bits,
    input logic                 flush,
    input logic                 cmd_done,
    input logic                 cmd_mode,
    input logic [LW-1:0]        cmd_len,
    input logic [PW:0]          fifo_flags,
    input logic signed [CW-1:0] byte_count,
    input logic                 overrun
);
    AST_FLAGS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flags <= (PW+1)'(DATA_DEPTH - 1)); // R3

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(host_wr)); // R3

    AST_CMDLEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len <= LW'(CMD_DEPTH)); // R8

    AST_READ_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !flush && phase_bits != 2'b00 && fifo_flags != '0)
        |=> (fifo_flags == $past(fifo_flags) - 1'b1)); // R4

    AST_PHASE0_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !flush && phase_bits == 2'b00)
        |=> (host_rdata == '0 && $stable(fifo_flags))); // R5

    AST_CMD_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mode && host_wr && !flush) |=> $stable(fifo_flags)); // R7

    AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (!cmd_mode && cmd_len == '0)); // R9

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_flags == '0 && byte_count == '0)); // R10

    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd) |=> $stable(host_rdata)); // R11
endmodule

bind hostfifo_redirect hostfifo_redirect_chk #(
    .DATA_DEPTH (DATA_DEPTH),
    .CMD_DEPTH  (CMD_DEPTH),
    .DW         (DW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .phase_bits (phase_bits),
    .flush      (flush),
    .cmd_done   (cmd_done),
    .cmd_mode   (cmd_mode),
    .cmd_len    (cmd_len),
    .fifo_flags (fifo_flags),
    .byte_count (byte_count),
    .overrun    (overrun)
);

// File: tb/hostfifo_redirect_tb.sv
`timescale 1ns/1ps
module hostfifo_redirect_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic [7:0]        host_wdata = 8'h00;
    logic              host_rd = 1'b0;
    logic [7:0]        host_rdata;
    logic [1:0]        phase_bits = 2'b01;
    logic              flush = 1'b0;
    logic              sel_stop = 1'b0;
    logic              cmd_done = 1'b0;
    logic              cmd_mode;
    logic [5:0]        cmd_len;
    logic [4:0]        cmd_idx = 5'd0;
    logic [7:0]        cmd_byte;
    logic [4:0]        fifo_flags;
    logic signed [5:0] byte_count;
    logic              overrun;

    int total = 0;
    int bad = 0;
    logic   rd_fired = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    hostfifo_redirect dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .phase_bits(phase_bits),
        .flush(flush), .sel_stop(sel_stop), .cmd_done(cmd_done),
        .cmd_mode(cmd_mode), .cmd_len(cmd_len), .cmd_idx(cmd_idx),
        .cmd_byte(cmd_byte), .fifo_flags(fifo_flags), .byte_count(byte_count),
        .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: a read accepted at an edge is compared on the next falling edge
    always @(posedge clk) rd_fired <= host_rd && !host_wr && !flush;

    always @(negedge clk) begin
        if (rd_fired) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "SCOREBOARD", int'(host_rdata), -1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk_eq(t, int'(host_rdata), int'(e));
            end
        end
    end

    task automatic wr_byte(input logic [7:0] b);
        host_wr = 1'b1;
        host_wdata = b;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    initial begin
        #1_000_000;
        check(1'b0, "WATCHDOG", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 flags", int'(fifo_flags), 0);
        chk_eq("R1 count", int'(byte_count), 0);
        chk_eq("R1 mode", int'(cmd_mode), 0);
        chk_eq("R1 cmd_len", int'(cmd_len), 0);
        chk_eq("R1 overrun", int'(overrun), 0);
        chk_eq("R1 rdata", int'(host_rdata), 0);

        // R2 data writes
        wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3);
        chk_eq("R2 flags", int'(fifo_flags), 3);
        chk_eq("R2 count", int'(byte_count), 3);

        // R4 ordered reads
        rd_expect(8'hA1, "R4 first");
        chk_eq("R4 flags", int'(fifo_flags), 2);
        chk_eq("R4 count", int'(byte_count), 2);
        rd_expect(8'hB2, "R4 second");
        rd_expect(8'hC3, "R4 third");
        chk_eq("R6 drained flags", int'(fifo_flags), 0);

        // R6 empty read keeps data and count
        rd_expect(8'hC3, "R6 empty read keeps rdata");
        chk_eq("R6 empty count", int'(byte_count), 0);

        // R3/R6 full capacity available after drain
        for (int i = 0; i < 15; i++) begin
            wr_byte(8'h10 + 8'(i));
            chk_eq("R6 accepted no overrun", int'(overrun), 0);
        end
        chk_eq("R6 flags 15", int'(fifo_flags), 15);
        wr_byte(8'hEE);
        chk_eq("R3 overrun pulse", int'(overrun), 1);
        chk_eq("R3 flags held", int'(fifo_flags), 15);
        tick();
        chk_eq("R3 pulse one cycle", int'(overrun), 0);

        for (int i = 0; i < 5; i++) rd_expect(8'h10 + 8'(i), "R4 partial drain");
        chk_eq("R4 flags 10", int'(fifo_flags), 10);
        wr_byte(8'hEF);
        chk_eq("R3 overrun after partial read", int'(overrun), 1);
        chk_eq("R3 flags 10", int'(fifo_flags), 10);

        // R5 data-out phase read
        phase_bits = 2'b00;
        rd_expect(8'h00, "R5 phase zero read");
        chk_eq("R5 flags kept", int'(fifo_flags), 10);
        chk_eq("R5 count kept", int'(byte_count), 10);
        phase_bits = 2'b10;
        rd_expect(8'h15, "R5 next read after phase zero");

        // R10 flush drops concurrent write
        flush = 1'b1; host_wr = 1'b1; host_wdata = 8'h77;
        tick();
        flush = 1'b0; host_wr = 1'b0;
        chk_eq("R10 flags", int'(fifo_flags), 0);
        chk_eq("R10 count", int'(byte_count), 0);
        chk_eq("R10 no overrun", int'(overrun), 0);
        wr_byte(8'hD4);
        rd_expect(8'hD4, "R10 pointers restart");

        // R11 simultaneous strobes
        host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'hE5;
        tick();
        host_rd = 1'b0; host_wr = 1'b0;
        chk_eq("R11 rdata kept", int'(host_rdata), 8'hD4);
        chk_eq("R11 write taken", int'(fifo_flags), 1);
        rd_expect(8'hE5, "R11 byte stored");

        // R7 command mode
        sel_stop = 1'b1; tick(); sel_stop = 1'b0;
        chk_eq("R9 enter cmd", int'(cmd_mode), 1);
        wr_byte(8'h41); wr_byte(8'h42); wr_byte(8'h43);
        chk_eq("R7 cmd_len", int'(cmd_len), 3);
        chk_eq("R7 data untouched", int'(fifo_flags), 0);
        for (int i = 0; i < 3; i++) begin
            cmd_idx = 5'(i);
            #1;
            chk_eq("R7 cmd byte", int'(cmd_byte), 8'h41 + i);
        end
        flush = 1'b1; tick(); flush = 1'b0;
        chk_eq("R10 cmd kept on flush", int'(cmd_len), 3);

        // R8 command overrun
        for (int i = 0; i < 29; i++) wr_byte(8'h50 + 8'(i));
        chk_eq("R8 cmd full", int'(cmd_len), 32);
        chk_eq("R8 no overrun yet", int'(overrun), 0);
        cmd_idx = 5'd31;
        #1;
        chk_eq("R7 last cmd byte", int'(cmd_byte), 8'h50 + 28);
        wr_byte(8'h99);
        chk_eq("R8 overrun", int'(overrun), 1);
        chk_eq("R8 len held", int'(cmd_len), 32);

        // R9 dispatch wins over enter
        sel_stop = 1'b1; cmd_done = 1'b1; tick();
        sel_stop = 1'b0; cmd_done = 1'b0;
        chk_eq("R9 back to data", int'(cmd_mode), 0);
        chk_eq("R9 len cleared", int'(cmd_len), 0);
        wr_byte(8'h3C);
        chk_eq("R9 write to data", int'(fifo_flags), 1);
        chk_eq("R9 cmd untouched", int'(cmd_len), 0);

        tick(); tick();
        chk_eq("SCOREBOARD empty", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule